// File: doc/BRIEF.md
# Correction-Mask Tick Rate Adjuster

This block turns a periodic base tick (nominally one pulse every 10 ms) into a trimmed real-time count. It keeps two counters. A raw counter advances by exactly one on every tick and wraps freely. A corrected counter normally advances by one per tick as well. On selected ticks it advances by two, which makes the clock gain a tick, or stays where it is, which makes the clock lose a tick.

The selection uses the post-increment raw value. The position of its lowest set bit is matched against a programmable correction mask. Raw values whose lowest set bit sits at position k occur once every 2^(k+1) ticks, so each mask position contributes a binary-weighted share of corrections, and those corrections are spread evenly over time. A single direction bit in the mask decides whether every selected tick is doubled or dropped. Software, or a calibration step, writes a mask once. The block then applies the trim continuously with no further attention.

Top module: `tick_rate_adjuster`

## Requirements
- R1: After reset `raw_count` and `corr_count` are zero and `corr_wrap` is low.
- R2: On every cycle with `tick` high, `raw_count` becomes `raw_count + 1` modulo 2^RAW_W (wrapping from all ones to zero), whatever the mask holds.
- R3: On a cycle with `tick` low, both counters keep their values and `corr_wrap` is low in the following cycle, even while `corr_mask` changes.
- R4: On a tick, let n be the incremented raw value. If n is nonzero and its lowest set bit is at position k, the tick is selected when `corr_mask[k+1]` is 1. If n is zero, the tick is never selected.
- R5: A selected tick with `corr_mask[0]` = 1 advances `corr_count` by 2.
- R6: A selected tick with `corr_mask[0]` = 0 leaves `corr_count` unchanged.
- R7: A tick that is not selected advances `corr_count` by 1.
- R8: The mask is sampled in the same cycle as the tick. A new mask applied in the cycle of a tick governs that tick and every later one.
- R9: `corr_wrap` is high for exactly the one cycle after a tick whose step carries `corr_count` past its maximum value, modulo 2^COR_W. It is low at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Base tick strobe, one cycle per period |
| corr_mask | input | RAW_W+1 | Bit 0 is the direction (1 = gain, 0 = lose); bit k+1 selects lowest-set-bit position k |
| raw_count | output | RAW_W | Free-running tick count |
| corr_count | output | COR_W | Corrected real-time count |
| corr_wrap | output | 1 | One-cycle pulse when the corrected count wraps |

## Verification
A correction step and a wrap of the corrected counter can land in the same cycle. This happens when a doubled tick carries the count from its top value, or from one below it, through zero. The bench builds the block with an 8-bit corrected counter and sets every position bit with gain direction, so most ticks add two. It then ticks through the wrap boundary and, separately, crosses it with plain single steps. The bench judges each tick against its own model of the value after the step and of the carry pulse. It also makes a mask change in the same cycle as a tick and checks that the new mask governs that tick.

// File: rtl/tra_pkg.sv
package tra_pkg;

  // Amount added to the corrected counter on one tick.
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_ONE  = 2'd1,
    STEP_TWO  = 2'd2
  } step_e;

  // A selected tick either doubles or is dropped; others advance by one.
  function automatic step_e pick_step(input logic hit, input logic dir_up);
    if (!hit)
      return STEP_ONE;
    return dir_up ? STEP_TWO : STEP_HOLD;
  endfunction

  // Widen a step so it can be added to a counter of the given width plus carry.
  function automatic logic [63:0] step_value(input step_e s);
    return {62'd0, s};
  endfunction

endpackage

// File: rtl/tra_raw_counter.sv
module tra_raw_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] raw_q,
  output logic [W-1:0] raw_next
);

  assign raw_next = raw_q + {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)
      raw_q <= '0;
    else if (tick)
      raw_q <= raw_next;
  end

endmodule

// File: rtl/tra_lowest_match.sv
module tra_lowest_match #(
  parameter int W = 16
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] pos_mask,
  output logic [W-1:0] first_one,
  output logic         hit
);

  logic [W-1:0] seen;

  assign seen[0]      = value[0];
  assign first_one[0] = value[0];

  // Ripple priority chain: a bit is the first one when no lower bit was set.
  for (genvar i = 1; i < W; i++) begin : g_chain
    assign first_one[i] = value[i] & ~seen[i-1];
    assign seen[i]      = seen[i-1] | value[i];
  end

  assign hit = |(first_one & pos_mask);

endmodule

// File: rtl/tra_step_accum.sv
module tra_step_accum
  import tra_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  step_e        step,
  output logic [W-1:0] acc_q,
  output logic         wrap_q
);

  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, acc_q} + step_value(step)[W:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= tick & sum[W];
      if (tick)
        acc_q <= sum[W-1:0];
    end
  end

endmodule

// File: rtl/tick_rate_adjuster.sv
module tick_rate_adjuster
  import tra_pkg::*;
#(
  parameter int RAW_W = 16,
  parameter int COR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [RAW_W:0]   corr_mask,
  output logic [RAW_W-1:0] raw_count,
  output logic [COR_W-1:0] corr_count,
  output logic             corr_wrap
);

  localparam int POS_W = RAW_W;

  // Named internal events, visible to the bound checker.
  logic [RAW_W-1:0] raw_next;
  logic [POS_W-1:0] first_one;
  logic             hit;
  logic             dir_up;
  step_e            step;

  assign dir_up = corr_mask[0];

  tra_raw_counter #(.W(RAW_W)) u_raw (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .raw_q    (raw_count),
    .raw_next (raw_next)
  );

  tra_lowest_match #(.W(POS_W)) u_match (
    .value     (raw_next),
    .pos_mask  (corr_mask[RAW_W:1]),
    .first_one (first_one),
    .hit       (hit)
  );

  always_comb begin
    step = pick_step(hit, dir_up);
  end

  tra_step_accum #(.W(COR_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .step   (step),
    .acc_q  (corr_count),
    .wrap_q (corr_wrap)
  );

endmodule

// File: rtl/tra_checker.sv
module tra_checker #(
  parameter int RAW_W = 16,
  parameter int COR_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [RAW_W:0]   corr_mask,
  input logic [RAW_W-1:0] raw_count,
  input logic [RAW_W-1:0] raw_next,
  input logic [RAW_W-1:0] first_one,
  input logic             hit,
  input logic [COR_W-1:0] corr_count,
  input logic             corr_wrap
);

  AST_RAW_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    tick |=> raw_count == RAW_W'($past(raw_count) + 1'b1)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(raw_count) && $stable(corr_count) && !corr_wrap); // R3

  AST_ZERO_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (tick && raw_next == '0) |-> !hit && first_one == '0); // R4

  AST_FIRST_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(first_one)); // R4

  AST_GAIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && hit && corr_mask[0]) |=> corr_count == COR_W'($past(corr_count) + 2'd2)); // R5

  AST_LOSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tick && hit && !corr_mask[0]) |=> $stable(corr_count)); // R6

  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !hit) |=> corr_count == COR_W'($past(corr_count) + 1'b1)); // R7

  AST_WRAP_MATCH: assert property (@(posedge clk) disable iff (rst)
    tick |=> corr_wrap == (corr_count < $past(corr_count))); // R9

endmodule

bind tick_rate_adjuster tra_checker #(.RAW_W(RAW_W), .COR_W(COR_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .corr_mask  (corr_mask),
  .raw_count  (raw_count),
  .raw_next   (raw_next),
  .first_one  (first_one),
  .hit        (hit),
  .corr_count (corr_count),
  .corr_wrap  (corr_wrap)
);

// File: tb/test_tick_rate_adjuster.sv
module test_tick_rate_adjuster;

  localparam int RAW_W = 16;
  localparam int COR_W = 8;

  typedef struct {
    logic [RAW_W-1:0] raw;
    logic [COR_W-1:0] cor;
    logic             wrap;
    string            tag;
  } item_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tick = 1'b0;
  logic [RAW_W:0]   corr_mask = '0;
  logic [RAW_W-1:0] raw_count;
  logic [COR_W-1:0] corr_count;
  logic             corr_wrap;

  int checks = 0;
  int errors = 0;
  item_t exp_q[$];

  logic [RAW_W-1:0] m_raw = '0;
  logic [COR_W-1:0] m_cor = '0;

  always #5 clk = ~clk;

  tick_rate_adjuster #(.RAW_W(RAW_W), .COR_W(COR_W)) i_tick_rate_adjuster (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .corr_mask  (corr_mask),
    .raw_count  (raw_count),
    .corr_count (corr_count),
    .corr_wrap  (corr_wrap)
  );

  // Driver: one tick with a given mask; the model result is queued after the edge.
  task automatic tick_once(input logic [RAW_W:0] m, input string tag);
    logic [RAW_W-1:0] n, low;
    logic             sel;
    logic [COR_W:0]   sum;
    item_t            it;
    @(negedge clk);
    tick = 1'b1;
    corr_mask = m;
    @(posedge clk);
    #1;
    n   = m_raw + 1'b1;
    low = n & (~n + 1'b1);
    sel = |(low & m[RAW_W:1]);
    if (sel && m[0])      sum = {1'b0, m_cor} + 9'd2;
    else if (sel)         sum = {1'b0, m_cor};
    else                  sum = {1'b0, m_cor} + 9'd1;
    m_raw = n;
    m_cor = sum[COR_W-1:0];
    it.raw = m_raw; it.cor = m_cor; it.wrap = sum[COR_W]; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic idle_once(input logic [RAW_W:0] m, input string tag);
    item_t it;
    @(negedge clk);
    tick = 1'b0;
    corr_mask = m;
    @(posedge clk);
    #1;
    it.raw = m_raw; it.cor = m_cor; it.wrap = 1'b0; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Monitor: compare one expected item per cycle, away from the active edge.
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      item_t e;
      e = exp_q.pop_front();
      checks++;
      if (raw_count !== e.raw || corr_count !== e.cor || corr_wrap !== e.wrap) begin
        errors++;
        $display("FAIL %s: raw=%0d cor=%0d wrap=%0b expected raw=%0d cor=%0d wrap=%0b",
                 e.tag, raw_count, corr_count, corr_wrap, e.raw, e.cor, e.wrap);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checks++;
    if (raw_count !== '0 || corr_count !== '0 || corr_wrap !== 1'b0) begin
      errors++;
      $display("FAIL R1: raw=%0d cor=%0d wrap=%0b expected 0 0 0", raw_count, corr_count, corr_wrap);
    end

    // R3: no tick, mask moving
    idle_once(17'h1FFFF, "R3");
    idle_once(17'h00002, "R3");
    idle_once(17'h0AAAA, "R3");

    // R7: empty mask, every tick advances by one
    for (int i = 0; i < 12; i++) tick_once(17'h00000, "R7");

    // R5: position 0 with gain direction: odd values double
    for (int i = 0; i < 12; i++) tick_once(17'h00003, "R5");

    // R6: position 1 with lose direction: values 2 mod 4 are dropped
    for (int i = 0; i < 12; i++) tick_once(17'h00004, "R6");

    // R4: higher positions only (bits 2 and 4) with gain
    for (int i = 0; i < 40; i++) tick_once(17'h00029, "R4");

    // R8: mask switched in the same cycle as a tick, alternating each tick
    for (int i = 0; i < 16; i++)
      tick_once((i % 2 == 0) ? 17'h1FFFF : 17'h00000, "R8");
    idle_once(17'h1FFFE, "R3");
    tick_once(17'h1FFFE, "R8");

    // R9: crossing the top with mostly doubled steps, then with single steps
    for (int i = 0; i < 140; i++) tick_once(17'h1FFFF, "R9");
    for (int i = 0; i < 260; i++) tick_once(17'h00000, "R9");

    // R2 and R4: run the raw counter through its wrap with every position losing;
    // only the zero value is unselected and advances the corrected count.
    while (m_raw != '1) tick_once(17'h1FFFE, "R2");
    tick_once(17'h1FFFE, "R4");
    for (int i = 0; i < 4; i++) tick_once(17'h1FFFE, "R2");
    idle_once(17'h00000, "R3");

    @(negedge clk);
    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule